// File: doc/BRIEF.md
# I2C Interrupt Vector Unit

This block sits beside an I2C bus engine. It gathers the engine's one-cycle event pulses into sticky flags and gives a host three 16-bit registers. The first is an enable mask. The second is a status word. The third is a vector register that names the most urgent event that is both pending and enabled. One interrupt request line is high while any enabled flag is pending.

The seven events are arbitration lost, no-acknowledge, register-access ready, receive ready, transmit ready, stop detected and addressed-as-slave. Each event clears in its own way:

- Reading the vector register clears the three error-like events when it reports them.
- Writing a one to the status register clears the access-ready and stop flags.
- A receive-data read clears receive ready.
- A transmit-data write clears transmit ready.

A bus-busy indication follows START and STOP pulses from the engine. It has no vector code and cannot raise the interrupt.

Register access is one cycle per access: `reg_sel` selects the block, `reg_wr` selects the direction, and `reg_addr` is the byte offset. Read data is combinational from the registered state. Side effects of an access take place at the clock edge that ends the access.

Top module: `ivec_unit`

## Requirements
- R1: After reset every event flag, the mask and bus-busy are 0, `irq` is 0, and the mask, status and vector registers all read 0 (with `rx_full` low).
- R2: A pulse on `ev_pulse[i]` sets flag i from the next cycle. The flag stays set until its own clear rule fires. A set and a clear of the same flag in one cycle leave it set.
- R3: The mask register is at offset 0x04 and is read/write. Its bits 6..0 enable arbitration-lost (bit0), no-ack (bit1), access-ready (bit2), receive-ready (bit3), transmit-ready (bit4), stop (bit5) and addressed-as-slave (bit6). Bits 15..7 read 0. The same bit order indexes `ev_pulse`.
- R4: A read of the vector register at offset 0x28 returns the code of the lowest-numbered pending enabled event, or 0 if none. The codes are arbitration-lost=1, no-ack=2, access-ready=3, receive-ready=4, transmit-ready=5, stop=6 and addressed-as-slave=7. A masked flag is never reported.
- R5: `irq` is high exactly when some flag is pending with its mask bit set.
- R6: A vector read that reports code 1, 2 or 7 clears that flag. A vector read that reports any other code leaves it pending.
- R7: The status register is at offset 0x08. It reads arbitration-lost at bit0, no-ack at bit1, access-ready at bit2, stop at bit5, `rx_full` at bit11 and bus-busy at bit12; all other bits read 0. Writing 1 to bit2 or bit5 clears that flag. Writing to any other status bit has no effect.
- R8: A pulse on `rx_pop` clears receive-ready and a pulse on `tx_push` clears transmit-ready.
- R9: `bus_start` sets bus-busy and `bus_stop` clears it; when both arrive in one cycle, busy is set. Bus-busy never drives `irq`.
- R10: Reads of unmapped offsets return 0. Writes to the vector register or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current address |
| ev_pulse | input | 7 | Event pulses from the bus engine, indexed as the mask bits |
| bus_start | input | 1 | START seen on the bus |
| bus_stop | input | 1 | STOP seen on the bus |
| rx_full | input | 1 | Receive shift register full, a level shown in status |
| rx_pop | input | 1 | Receive data register was read |
| tx_push | input | 1 | Transmit data register was written |
| irq | output | 1 | Interrupt request |

## Verification
A flag that fails to set or clear is visible within one cycle: `irq` changes, and the next vector read returns the wrong code. A wrong code also goes on to clear the wrong flag, so a sequence of vector reads that should step through 1, 2, 7 and then 0 exposes it at the first read that goes wrong. A mask bit that is stored wrong shows either as a missing interrupt or as a code the host never enabled. A bus-busy bit that is wrong shows in bit 12 of status on the cycle after the START or STOP pulse.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    localparam int EV_N     = 7;
    localparam int REG_W    = 16;
    localparam int OFS_W    = 8;
    localparam int CODE_W   = $clog2(EV_N + 1);

    // event index = mask bit = code - 1
    localparam int IX_ARB   = 0;
    localparam int IX_NAK   = 1;
    localparam int IX_RDY   = 2;
    localparam int IX_RXR   = 3;
    localparam int IX_TXR   = 4;
    localparam int IX_STP   = 5;
    localparam int IX_SLV   = 6;

    localparam int ST_RXF   = 11;
    localparam int ST_BUSY  = 12;

    localparam logic [OFS_W-1:0] OFS_MASK = 8'h04;
    localparam logic [OFS_W-1:0] OFS_STAT = 8'h08;
    localparam logic [OFS_W-1:0] OFS_VEC  = 8'h28;

    typedef struct packed {
        logic [EV_N-1:0] mask;
        logic            busy;
    } ctl_t;
endpackage

// File: rtl/ivec_flag_bank.sv
module ivec_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q, nxt;

    // set has priority over a clear in the same cycle
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign nxt[g] = set_i[g] | (flag_q[g] & ~clr_i[g]);
    end

    always_comb begin
        flag_d = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ivec_prio.sv
module ivec_prio #(
    parameter int N  = 7,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  pend_i,
    output logic [CW-1:0] code_o
);
    // scan downward so the lowest index is written last and wins
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) code_o = CW'(i + 1);
        end
    end
endmodule

// File: rtl/ivec_unit.sv
module ivec_unit
    import ivec_pkg::*;
#(
    parameter int N_EV = EV_N,
    parameter int DW   = REG_W,
    parameter int AW   = OFS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_sel,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [N_EV-1:0] ev_pulse,
    input  logic            bus_start,
    input  logic            bus_stop,
    input  logic            rx_full,
    input  logic            rx_pop,
    input  logic            tx_push,
    output logic            irq
);
    localparam int CW = $clog2(N_EV + 1);

    ctl_t            st_d, st_q;
    logic [N_EV-1:0] flag_q, clr, pend;
    logic [CW-1:0]   code;
    logic            wr_mask, wr_stat, rd_vec;

    assign wr_mask = reg_sel &  reg_wr && reg_addr == AW'(OFS_MASK);
    assign wr_stat = reg_sel &  reg_wr && reg_addr == AW'(OFS_STAT);
    assign rd_vec  = reg_sel & ~reg_wr && reg_addr == AW'(OFS_VEC);

    assign pend = flag_q & st_q.mask;
    assign irq  = |pend;

    ivec_prio #(.N(N_EV), .CW(CW)) u_prio (
        .pend_i (pend),
        .code_o (code)
    );

    always_comb begin
        clr         = '0;
        clr[IX_ARB] = rd_vec && code == CW'(IX_ARB + 1);
        clr[IX_NAK] = rd_vec && code == CW'(IX_NAK + 1);
        clr[IX_SLV] = rd_vec && code == CW'(IX_SLV + 1);
        clr[IX_RDY] = wr_stat & reg_wdata[IX_RDY];
        clr[IX_STP] = wr_stat & reg_wdata[IX_STP];
        clr[IX_RXR] = rx_pop;
        clr[IX_TXR] = tx_push;
    end

    ivec_flag_bank #(.N(N_EV)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_pulse),
        .clr_i  (clr),
        .flag_o (flag_q)
    );

    always_comb begin
        st_d = st_q;
        if (wr_mask)        st_d.mask = reg_wdata[N_EV-1:0];
        if (bus_stop)       st_d.busy = 1'b0;
        if (bus_start)      st_d.busy = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFS_MASK)) begin
            reg_rdata[N_EV-1:0] = st_q.mask;
        end else if (reg_addr == AW'(OFS_STAT)) begin
            reg_rdata[IX_ARB]  = flag_q[IX_ARB];
            reg_rdata[IX_NAK]  = flag_q[IX_NAK];
            reg_rdata[IX_RDY]  = flag_q[IX_RDY];
            reg_rdata[IX_STP]  = flag_q[IX_STP];
            reg_rdata[ST_RXF]  = rx_full;
            reg_rdata[ST_BUSY] = st_q.busy;
        end else if (reg_addr == AW'(OFS_VEC)) begin
            reg_rdata[CW-1:0] = code;
        end
    end
endmodule

// File: rtl/ivec_checker.sv
module ivec_checker
    import ivec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [OFS_W-1:0]  reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [EV_N-1:0]   ev_pulse,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              irq,
    input logic [EV_N-1:0]   flags,
    input logic [EV_N-1:0]   mask,
    input logic              busy
);
    logic vrd, mwr, swr;
    assign vrd = reg_sel && !reg_wr && reg_addr == OFS_VEC;
    assign mwr = reg_sel &&  reg_wr && reg_addr == OFS_MASK;
    assign swr = reg_sel &&  reg_wr && reg_addr == OFS_STAT;

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[IX_RDY] |=> flags[IX_RDY]);

    p_mask_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mwr |=> mask == $past(reg_wdata[EV_N-1:0]));

    p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vrd |-> reg_rdata <= REG_W'(EV_N));

    p_irq_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vrd |-> irq == (reg_rdata != '0));

    p_vec_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd && reg_rdata == 16'd1 && !ev_pulse[IX_ARB]) |=> !flags[IX_ARB]);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[IX_RDY] && !(swr && reg_wdata[IX_RDY])) |=> flags[IX_RDY]);

    p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> busy);

    p_busy_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !bus_start) |=> !busy);
endmodule

bind ivec_unit ivec_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev_pulse  (ev_pulse),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .irq       (irq),
    .flags     (flag_q),
    .mask      (st_q.mask),
    .busy      (st_q.busy)
);

// File: tb/sim_ivec_unit.sv
module sim_ivec_unit;
    localparam int PERIOD = 10;
    localparam logic [7:0] A_MASK = 8'h04, A_STAT = 8'h08, A_VEC = 8'h28;

    logic        clk = 0, rst_n = 0;
    logic        reg_sel = 0, reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic [6:0]  ev_pulse = 0;
    logic        bus_start = 0, bus_stop = 0, rx_full = 0, rx_pop = 0, tx_push = 0;
    logic        irq;
    int          total = 0, bad = 0;

    always #(PERIOD/2) clk = ~clk;

    ivec_unit u0 (.*);

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        @(negedge clk); reg_sel = 1; reg_wr = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_sel = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_sel = 0; reg_wr = 0;
    endtask

    task automatic pulse(logic [6:0] ev);
        @(negedge clk); ev_pulse = ev;
        @(negedge clk); ev_pulse = 0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 mask", A_MASK, 16'h0);
        rd_chk("R1 status", A_STAT, 16'h0);
        rd_chk("R1 vector", A_VEC, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_mask;
        wr(A_MASK, 16'hFFFF);
        rd_chk("R3 mask upper bits", A_MASK, 16'h007F);
        wr(A_MASK, 16'h0000);
        rd_chk("R3 mask cleared", A_MASK, 16'h0);
    endtask

    task automatic t_prio_and_status;
        pulse(7'b011_0100);                       // ready, tx ready, stop
        rd_chk("R4 masked vector", A_VEC, 16'h0);
        chk("R5 irq masked", {15'd0, irq}, 16'h0);
        wr(A_MASK, 16'h007F);
        #1 chk("R5 irq enabled", {15'd0, irq}, 16'h1);
        rd_chk("R4 lowest code", A_VEC, 16'd3);
        rd_chk("R6 ready not cleared by read", A_VEC, 16'd3);
        rd_chk("R7 status bits", A_STAT, 16'h0024);
        wr(A_STAT, 16'h0004);
        rd_chk("R7 w1c ready", A_VEC, 16'd5);
        @(negedge clk); tx_push = 1; @(negedge clk); tx_push = 0;
        rd_chk("R8 tx push clears", A_VEC, 16'd6);
        wr(A_STAT, 16'hFFDF);
        rd_chk("R7 other bits ignored", A_VEC, 16'd6);
        wr(A_STAT, 16'h0020);
        rd_chk("R7 w1c stop", A_VEC, 16'd0);
        #1 chk("R5 irq low", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_vec_clear;
        pulse(7'b100_0011);
        rd_chk("R7 error bits", A_STAT, 16'h0003);
        wr(A_STAT, 16'h0003);
        rd_chk("R7 arb/nak not w1c", A_STAT, 16'h0003);
        rd_chk("R6 first read", A_VEC, 16'd1);
        rd_chk("R6 second read", A_VEC, 16'd2);
        rd_chk("R6 third read", A_VEC, 16'd7);
        rd_chk("R6 drained", A_VEC, 16'd0);
    endtask

    task automatic t_rx;
        pulse(7'b000_1000);
        rd_chk("R2 rx ready set", A_VEC, 16'd4);
        rd_chk("R6 rx ready kept", A_VEC, 16'd4);
        @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
        rd_chk("R8 rx pop clears", A_VEC, 16'd0);
    endtask

    task automatic t_mask_select;
        wr(A_MASK, 16'h0010);
        pulse(7'b001_0001);
        rd_chk("R4 masked arb skipped", A_VEC, 16'd5);
        wr(A_MASK, 16'h007F);
        rd_chk("R6 arb survived masked", A_VEC, 16'd1);
        rd_chk("R6 then tx ready", A_VEC, 16'd5);
        @(negedge clk); tx_push = 1; @(negedge clk); tx_push = 0;
    endtask

    task automatic t_set_wins;
        pulse(7'b000_0100);
        @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = A_STAT;
        reg_wdata = 16'h0004; ev_pulse = 7'b000_0100;
        @(negedge clk); reg_sel = 0; reg_wr = 0; ev_pulse = 0;
        rd_chk("R2 set beats clear", A_STAT, 16'h0004);
        wr(A_STAT, 16'h0004);
        rd_chk("R2 cleared later", A_STAT, 16'h0000);
    endtask

    task automatic t_busy;
        @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0;
        rd_chk("R9 busy set", A_STAT, 16'h1000);
        chk("R9 busy no irq", {15'd0, irq}, 16'h0);
        @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
        rd_chk("R9 busy cleared", A_STAT, 16'h0000);
        @(negedge clk); bus_start = 1; bus_stop = 1;
        @(negedge clk); bus_start = 0; bus_stop = 0;
        rd_chk("R9 start wins", A_STAT, 16'h1000);
        @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
        rx_full = 1;
        rd_chk("R7 rx full bit", A_STAT, 16'h0800);
        rx_full = 0;
    endtask

    task automatic t_unmapped;
        rd_chk("R10 unmapped read", 8'h10, 16'h0);
        wr(A_VEC, 16'hFFFF);
        wr(8'h14, 16'hFFFF);
        rd_chk("R10 mask untouched", A_MASK, 16'h007F);
        rd_chk("R10 vector still idle", A_VEC, 16'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                t_reset();
                t_mask();
                t_prio_and_status();
                t_vec_clear();
                t_rx();
                t_mask_select();
                t_set_wins();
                t_busy();
                t_unmapped();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule